// File: doc/BRIEF.md
# Mask-Sequenced Route Lookup

This block resolves the most specific route for a packet address with a binary content-addressable table whose entries all share one mask register. Each entry holds a stored address and a small associated-data value, and a separate bank holds an ordered list of distinct masks. The list is written most specific first, meaning the mask with the most 1 bits sits at index 0.

When a lookup is accepted, a sequencer walks the list. For each mask it spends one cycle loading the shared mask register and one cycle on the masked search. The walk stops at the first mask that produces a hit, and a final cycle reads the associated data. If no listed mask hits, one more step runs with an all-zeros mask. Under that mask, an entry whose stored address is zero serves as the default route.

Entries are added to the lowest free slot and removed by address. Table edits are refused while a lookup is in flight.

Top module: `seqmask_lookup`

## Requirements
- R1: An entry hits under mask M for packet address K when the entry is valid and (K & M) equals its stored address.
- R2: Masks are applied in list order starting at index 0. The walk ends at the first step with a hit, and that entry's data is returned with res_hit=1, plus res_dflt=1 only when the hit came in the all-zeros step.
- R3: If the walk runs s steps (the number of the hitting step, or list length plus one when nothing hits), res_valid is a one-cycle pulse 2*s+1 clock edges after the edge that accepts the request.
- R4: After the listed masks, a final step uses an all-zeros mask. If nothing hits there either, the result is res_hit=0, res_dflt=1 and res_data=0.
- R5: If several entries hit in the same step, the entry in the lowest-numbered slot is returned.
- R6: An insert places the entry in the lowest-numbered free slot, and the entry takes part in lookups accepted afterwards.
- R7: A delete invalidates every valid entry whose stored address equals del_addr, and the freed slots become reusable.
- R8: busy rises on the edge that accepts a request and falls on the edge that presents the result. A req_valid seen while busy is ignored and produces no result.
- R9: Insert and delete requests seen while busy are ignored.
- R10: An insert while all slots are valid leaves the table unchanged and raises ins_err for the following cycle. ins_err stays low otherwise.
- R11: A mask write at index i stores the mask and sets the list length to i+1.
- R12: After reset the table is empty, the list length is 0, and busy, res_valid and ins_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_addr | input | 32 | Address of the entry to insert |
| ins_data | input | 8 | Associated data of the entry to insert |
| del_valid | input | 1 | Delete request |
| del_addr | input | 32 | Stored address to remove |
| ins_err | output | 1 | Insert refused because the table was full |
| cfg_we | input | 1 | Mask list write strobe |
| cfg_idx | input | 3 | Mask list index being written |
| cfg_mask | input | 32 | Mask value written |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Packet address to resolve |
| busy | output | 1 | Lookup in flight |
| res_valid | output | 1 | Result strobe, one cycle |
| res_data | output | 8 | Associated data of the winning entry |
| res_hit | output | 1 | An entry was found |
| res_dflt | output | 1 | Result came from the all-zeros step |

## Verification
The bench targets addresses that first hit at each depth of a four-mask list, and checks the cycle on which each result appears. A design that skipped or reordered masks would return a less specific route, and one with a miscounted step would shift the result strobe. Duplicate stored addresses check lowest-slot priority and delete-all-copies behaviour. A sequencer that got the all-zeros step wrong would either report a default route after its entry was deleted or miss one that exists. Edits and a second request injected mid-walk, an insert into a full table, and a shortened mask list catch lockout, overflow and list-length errors.

// File: rtl/seqmask_pkg.sv
package seqmask_pkg;

    localparam int SM_ADDR_W  = 32;
    localparam int SM_DATA_W  = 8;
    localparam int SM_ENTRIES = 16;
    localparam int SM_MASKS   = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SEARCH,
        ST_READ
    } seq_state_e;

    typedef struct packed {
        logic hit;
        logic dflt;
    } res_flags_t;

endpackage

// File: rtl/seqmask_entry_store.sv
module seqmask_entry_store #(
    parameter int ADDR_W  = seqmask_pkg::SM_ADDR_W,
    parameter int DATA_W  = seqmask_pkg::SM_DATA_W,
    parameter int ENTRIES = seqmask_pkg::SM_ENTRIES,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               busy,
    input  logic               ins_valid,
    input  logic [ADDR_W-1:0]  ins_addr,
    input  logic [DATA_W-1:0]  ins_data,
    input  logic               del_valid,
    input  logic [ADDR_W-1:0]  del_addr,
    input  logic [ADDR_W-1:0]  key,
    input  logic [ADDR_W-1:0]  mask,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRIES-1:0] match,
    output logic [DATA_W-1:0]  rd_data,
    output logic               ins_err
);

    logic [ENTRIES-1:0]             vld_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] addr_q;
    logic [ENTRIES-1:0][DATA_W-1:0] data_q;
    logic [IDX_W-1:0]               free_slot;
    logic                           full;
    logic                           do_ins;

    assign full   = &vld_q;
    assign do_ins = ins_valid && !busy && !full;

    always_comb begin
        free_slot = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_slot = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= '0;
            ins_err <= 1'b0;
        end else begin
            ins_err <= ins_valid && !busy && full;
            if (!busy && del_valid) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (vld_q[i] && addr_q[i] == del_addr) vld_q[i] <= 1'b0;
                end
            end
            if (do_ins) vld_q[free_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_ins) begin
            addr_q[free_slot] <= ins_addr;
            data_q[free_slot] <= ins_data;
        end
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = vld_q[g] && ((key & mask) == addr_q[g]);
        end
    endgenerate

    assign rd_data = data_q[rd_idx];

    AST_EDIT_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(vld_q)) else $error("table changed while busy"); // R9

    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !busy && full) |=> (ins_err && $stable(vld_q)))
        else $error("full insert not refused"); // R10

endmodule

// File: rtl/seqmask_mask_bank.sv
module seqmask_mask_bank #(
    parameter int ADDR_W = seqmask_pkg::SM_ADDR_W,
    parameter int MASKS  = seqmask_pkg::SM_MASKS,
    localparam int MIDX_W = $clog2(MASKS),
    localparam int CNT_W  = $clog2(MASKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [MIDX_W-1:0] cfg_idx,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic [CNT_W-1:0]  sel,
    output logic [CNT_W-1:0]  list_len,
    output logic [ADDR_W-1:0] sel_mask
);

    logic [MASKS-1:0][ADDR_W-1:0] mask_q;
    logic [CNT_W-1:0]             len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
        end else if (cfg_we) begin
            len_q <= CNT_W'(cfg_idx) + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (cfg_we) mask_q[cfg_idx] <= cfg_mask;
    end

    assign list_len = len_q;
    assign sel_mask = (sel < len_q) ? mask_q[sel[MIDX_W-1:0]] : '0;

endmodule

// File: rtl/seqmask_seq.sv
module seqmask_seq #(
    parameter int ADDR_W  = seqmask_pkg::SM_ADDR_W,
    parameter int DATA_W  = seqmask_pkg::SM_DATA_W,
    parameter int ENTRIES = seqmask_pkg::SM_ENTRIES,
    parameter int MASKS   = seqmask_pkg::SM_MASKS,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(MASKS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [CNT_W-1:0]   list_len,
    input  logic [ADDR_W-1:0]  sel_mask,
    input  logic [ENTRIES-1:0] match,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [CNT_W-1:0]   step_q,
    output logic [ADDR_W-1:0]  key_q,
    output logic [ADDR_W-1:0]  mask_q,
    output logic [IDX_W-1:0]   win_q,
    output logic               busy,
    output logic               res_valid,
    output logic [DATA_W-1:0]  res_data,
    output logic               res_hit,
    output logic               res_dflt
);
    import seqmask_pkg::*;

    seq_state_e       state_q;
    res_flags_t       flags_q;
    res_flags_t       out_q;
    logic [IDX_W-1:0] win_c;
    logic             any_c;
    logic             last_step;

    assign last_step = (step_q == list_len);
    assign any_c     = |match;
    assign busy      = (state_q != ST_IDLE);

    always_comb begin
        win_c = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) win_c = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            step_q    <= '0;
            res_valid <= 1'b0;
            out_q     <= '0;
            res_data  <= '0;
            flags_q   <= '0;
        end else begin
            res_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    key_q   <= req_addr;
                    step_q  <= '0;
                    state_q <= ST_LOAD;
                end
                ST_LOAD: begin
                    mask_q  <= sel_mask;
                    state_q <= ST_SEARCH;
                end
                ST_SEARCH: begin
                    if (any_c || last_step) begin
                        flags_q <= '{hit: any_c, dflt: last_step};
                        win_q   <= win_c;
                        state_q <= ST_READ;
                    end else begin
                        step_q  <= step_q + CNT_W'(1);
                        state_q <= ST_LOAD;
                    end
                end
                ST_READ: begin
                    res_valid <= 1'b1;
                    out_q     <= flags_q;
                    res_data  <= flags_q.hit ? rd_data : '0;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign res_hit  = out_q.hit;
    assign res_dflt = out_q.dflt;

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy) else $error("request not taken"); // R8

    AST_RESULT_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> res_valid) else $error("busy dropped without result"); // R3

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid) else $error("result strobe too long"); // R3

    AST_MISS_IS_DFLT: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_dflt && res_data == '0))
        else $error("miss without default flag"); // R4

endmodule

// File: rtl/seqmask_lookup.sv
module seqmask_lookup #(
    parameter int ADDR_W  = seqmask_pkg::SM_ADDR_W,
    parameter int DATA_W  = seqmask_pkg::SM_DATA_W,
    parameter int ENTRIES = seqmask_pkg::SM_ENTRIES,
    parameter int MASKS   = seqmask_pkg::SM_MASKS,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int MIDX_W = $clog2(MASKS),
    localparam int CNT_W  = $clog2(MASKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              del_valid,
    input  logic [ADDR_W-1:0] del_addr,
    output logic              ins_err,
    input  logic              cfg_we,
    input  logic [MIDX_W-1:0] cfg_idx,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_hit,
    output logic              res_dflt
);

    logic [CNT_W-1:0]   step;
    logic [CNT_W-1:0]   list_len;
    logic [ADDR_W-1:0]  sel_mask;
    logic [ADDR_W-1:0]  key;
    logic [ADDR_W-1:0]  mask;
    logic [IDX_W-1:0]   win;
    logic [ENTRIES-1:0] match;
    logic [DATA_W-1:0]  rd_data;

    seqmask_entry_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)
    ) u_store (
        .clk(clk), .rst(rst), .busy(busy),
        .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data),
        .del_valid(del_valid), .del_addr(del_addr),
        .key(key), .mask(mask), .rd_idx(win),
        .match(match), .rd_data(rd_data), .ins_err(ins_err)
    );

    seqmask_mask_bank #(
        .ADDR_W(ADDR_W), .MASKS(MASKS)
    ) u_masks (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mask(cfg_mask),
        .sel(step), .list_len(list_len), .sel_mask(sel_mask)
    );

    seqmask_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .MASKS(MASKS)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr),
        .list_len(list_len), .sel_mask(sel_mask),
        .match(match), .rd_data(rd_data),
        .step_q(step), .key_q(key), .mask_q(mask), .win_q(win),
        .busy(busy), .res_valid(res_valid), .res_data(res_data),
        .res_hit(res_hit), .res_dflt(res_dflt)
    );

endmodule

// File: tb/seqmask_lookup_tb.sv
module seqmask_lookup_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic [31:0] ins_addr = '0;
    logic [7:0]  ins_data = '0;
    logic        del_valid = 1'b0;
    logic [31:0] del_addr = '0;
    logic        ins_err;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_mask = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        busy, res_valid, res_hit, res_dflt;
    logic [7:0]  res_data;

    seqmask_lookup u_dut (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data),
        .del_valid(del_valid), .del_addr(del_addr), .ins_err(ins_err),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mask(cfg_mask),
        .req_valid(req_valid), .req_addr(req_addr), .busy(busy),
        .res_valid(res_valid), .res_data(res_data),
        .res_hit(res_hit), .res_dflt(res_dflt)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic       hit;
        logic       dflt;
        logic [7:0] data;
        int         due;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // monitor: pops scoreboard on each result
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(res_hit == e.hit, {e.tag, " hit"}, res_hit, e.hit);
                chk(res_dflt == e.dflt, {e.tag, " dflt"}, res_dflt, e.dflt);
                chk(res_data == e.data, {e.tag, " data"}, res_data, e.data);
                chk(cyc == e.due, {e.tag, " R3 latency"}, cyc, e.due);
            end
        end
    end

    task automatic insert(input logic [31:0] a, input logic [7:0] d, input bit exp_err, input string tag);
        @(negedge clk);
        ins_valid = 1'b1; ins_addr = a; ins_data = d;
        @(negedge clk);
        ins_valid = 1'b0;
        chk(ins_err == exp_err, {tag, " ins_err"}, ins_err, exp_err);
    endtask

    task automatic remove(input logic [31:0] a);
        @(negedge clk);
        del_valid = 1'b1; del_addr = a;
        @(negedge clk);
        del_valid = 1'b0;
    endtask

    task automatic set_mask(input logic [2:0] i, input logic [31:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = i; cfg_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input bit h, input bit df, input logic [7:0] d,
                          input int steps, input bit noise, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        e.hit = h; e.dflt = df; e.data = d; e.tag = tag;
        e.due = cyc + 1 + 2 * steps + 1;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, {tag, " R8 busy after accept"}, busy, 1);
        if (noise) begin
            // R9 edits and R8 second request while busy
            ins_valid = 1'b1; ins_addr = 32'h0B00_0000; ins_data = 8'h99;
            del_valid = 1'b1; del_addr = 32'hC0A8_0000;
            req_valid = 1'b1; req_addr = 32'h0A00_0000;
            @(negedge clk);
            ins_valid = 1'b0; del_valid = 1'b0; req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(busy == 1'b0, "R12 busy", busy, 0);
        chk(res_valid == 1'b0, "R12 res_valid", res_valid, 0);
        chk(ins_err == 1'b0, "R12 ins_err", ins_err, 0);
        // R12 empty list and table: only the zero step runs
        lookup(32'h1234_5678, 0, 1, 8'h00, 1, 0, "R12 empty");

        set_mask(3'd0, 32'hFFFF_FFFF);
        set_mask(3'd1, 32'hFFFF_FF00);
        set_mask(3'd2, 32'hFFFF_0000);
        set_mask(3'd3, 32'hFF00_0000);
        insert(32'hC0A8_0105, 8'h11, 0, "R6 fill");
        insert(32'hC0A8_0100, 8'h22, 0, "R6 fill");
        insert(32'hC0A8_0000, 8'h33, 0, "R6 fill");
        insert(32'h0A00_0000, 8'h44, 0, "R6 fill");
        insert(32'h0000_0000, 8'h55, 0, "R4 default entry");

        // R1 R2 hits at each depth
        lookup(32'hC0A8_0105, 1, 0, 8'h11, 1, 0, "R2 depth1");
        lookup(32'hC0A8_0177, 1, 0, 8'h22, 2, 0, "R2 depth2");
        lookup(32'hC0A8_FF01, 1, 0, 8'h33, 3, 0, "R1 depth3");
        lookup(32'h0A12_3456, 1, 0, 8'h44, 4, 0, "R1 depth4");
        lookup(32'h0B00_0000, 1, 1, 8'h55, 5, 0, "R4 default hit");

        // R7 delete default route, then miss
        remove(32'h0000_0000);
        lookup(32'h0B00_0000, 0, 1, 8'h00, 5, 0, "R7 default deleted");

        // R5 duplicate lands in a higher slot; lower slot wins
        insert(32'hC0A8_0105, 8'h66, 0, "R5 dup");
        lookup(32'hC0A8_0105, 1, 0, 8'h11, 1, 0, "R5 lowest slot");
        remove(32'hC0A8_0105);
        lookup(32'hC0A8_0105, 1, 0, 8'h22, 2, 0, "R7 both copies gone");

        // R6 lowest free slot gets first insert
        insert(32'hC0A8_0177, 8'h77, 0, "R6 slot0");
        insert(32'hC0A8_0177, 8'h88, 0, "R6 slot4");
        lookup(32'hC0A8_0177, 1, 0, 8'h77, 1, 0, "R6 lowest free");

        // R8 R9 activity while busy
        lookup(32'hC0A8_0100, 1, 0, 8'h22, 1, 1, "R9 noisy");
        lookup(32'h0B00_0000, 0, 1, 8'h00, 5, 0, "R9 insert ignored");
        lookup(32'hC0A8_FF01, 1, 0, 8'h33, 3, 0, "R9 delete ignored");

        // R10 fill the remaining 11 slots, then overflow
        for (int i = 0; i < 11; i++)
            insert(32'h0100_0000 + i, 8'(i), 0, "R10 no error");
        insert(32'h7F00_0001, 8'hAA, 1, "R10 full");
        @(negedge clk);
        chk(ins_err == 1'b0, "R10 err one cycle", ins_err, 0);
        lookup(32'h7F00_0001, 0, 1, 8'h00, 5, 0, "R10 not stored");

        // R11 shorten list to two masks
        set_mask(3'd1, 32'hFFFF_FF00);
        lookup(32'h0A12_3456, 0, 1, 8'h00, 3, 0, "R11 short list");
        lookup(32'hC0A8_0177, 1, 0, 8'h77, 1, 0, "R11 still hits");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 results outstanding", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule